// File: doc/BRIEF.md
# Dual-Register DDS Phase Core

This block is the digital heart of a direct digital synthesizer. A 28-bit phase accumulator advances on every master clock edge by a tuning word drawn from one of two frequency registers, so the output frequency is `tuning_word * f_clk / 2^28`. The top 12 accumulator bits, plus a phase offset drawn from one of two phase registers, index a quarter-wave sine table whose result is unfolded into a 10-bit offset-binary code for a DAC. The offset is added after the accumulator, outside its feedback loop, so changing it shifts the phase without disturbing the running count.

Software programs the five registers through a plain parallel write port. Each register pair is chosen either by a dedicated input pin or by a bit of the control register, as a third control bit decides. A datapath reset returns the output to midscale while leaving every programmed register intact, a sleep pin or control bit drops the DAC enable, and a square-wave sign output follows the accumulator MSB when enabled.

Top module: `dds_phase_core`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register at `wr_addr` on the next clock edge: address 0 and 1 hold the two 28-bit tuning words, 2 and 3 hold the two 12-bit phase offsets (`wr_data[11:0]`), 4 holds the control word (`wr_data[5:0]`).
- R2: Control word bits: bit0 picks the select source (1 = control bits, 0 = pins), bit1 is the frequency select bit, bit2 the phase select bit, bit3 the sleep bit, bit4 output enable for the sign pin, bit5 the sign enable.
- R3: On every clock edge out of reset the accumulator adds the selected tuning word; a tuning word of 2^26 steps the phase by a quarter turn per clock, and a tuning word of 0 holds it still.
- R4: The frequency select (pin `fsel_pin` or control bit1) chooses tuning word 0 (value 0) or tuning word 1 (value 1).
- R5: The phase select (pin `psel_pin` or control bit2) chooses phase offset 0 or 1, added to the top 12 accumulator bits.
- R6: While control bit0 is 1 the select pins have no effect on the output; while it is 0 the select bits have none.
- R7: The DAC code for a 12-bit phase p is 512 + round(511 * sin(2*pi*p/4096)) sampled on a 1024-step grid: phase 0x000 gives 512, 0x200 gives 873, 0x400 gives 1023, 0x800 gives 512, 0xC00 gives 1.
- R8: While `rst` is high the accumulator and pipeline clear: `dac_code` reads 512 and `sign_out` reads 0 from the first edge of reset.
- R9: `rst` leaves the tuning words, phase offsets and control word unchanged.
- R10: `dac_en` is low whenever `sleep_pin` or control bit3 is high, and high otherwise.
- R11: With control bits 4 and 5 both set, `sign_out` equals the accumulator MSB of the same sample that produced `dac_code`; otherwise it is 0.
- R12: A select change reaches `dac_code` after three clock edges from a pin change, with no missed or doubled accumulator step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high datapath reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 28 | Register write data |
| fsel_pin | input | 1 | External frequency register select |
| psel_pin | input | 1 | External phase register select |
| sleep_pin | input | 1 | External DAC power-down request |
| dac_code | output | 10 | Offset-binary sine amplitude code |
| dac_en | output | 1 | DAC enable, low when asleep |
| sign_out | output | 1 | Square-wave output from accumulator MSB |

## Verification
The bench drives exact quarter-turn phases so the table's endpoints and the unfolding of all four quadrants are checked against fixed codes; a mirrored or sign-swapped quadrant would return 1 where 1023 is due. It toggles each select pin while software selection is active, where a design that still honoured the pin would move a frozen output. It pulses reset mid-run and then expects the prior phase offset to reappear, which a design that cleared its registers on reset would lose. With a quarter-turn tuning word it follows the 512/1023/512/1 cycle edge by edge together with the sign pin, catching a skipped step or a sign bit that is one stage out of line.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int ACC_W   = 28;
    localparam int PH_W    = 12;
    localparam int DAC_W   = 10;
    localparam int LUT_AW  = 8;
    localparam int ADDR_W  = 3;
    localparam int NPAIR   = 2;
    localparam int CTRL_W  = 6;

    localparam int FREQ_BASE  = 0;
    localparam int PHASE_BASE = 2;
    localparam int CTRL_ADDR  = 4;

    localparam int LUT_N   = 1 << LUT_AW;
    localparam int AMP_W   = DAC_W - 1;
    localparam logic [DAC_W-1:0] MIDSCALE = DAC_W'(1 << (DAC_W - 1));

    typedef logic [ACC_W-1:0] tune_t;
    typedef logic [PH_W-1:0]  phase_t;

    typedef struct packed {
        logic sign_en;
        logic out_en;
        logic sleep;
        logic psel;
        logic fsel;
        logic sw_sel;
    } ctrl_t;

    typedef struct packed {
        logic   msb;
        phase_t phase;
    } stage_t;

    function automatic logic [AMP_W-1:0] quarter_amp(input int idx);
        real ang;
        real amp;
        ang = real'(idx) * 3.14159265358979 / real'(2 * LUT_N);
        amp = $sin(ang) * real'((1 << AMP_W) - 1);
        return AMP_W'($rtoi(amp + 0.5));
    endfunction
endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    output tune_t             freq_o  [NPAIR],
    output phase_t            phase_o [NPAIR],
    output ctrl_t             ctrl_o
);
    tune_t  freq_q  [NPAIR];
    phase_t phase_q [NPAIR];
    ctrl_t  ctrl_q;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        localparam logic [ADDR_W-1:0] FA = ADDR_W'(FREQ_BASE + g);
        localparam logic [ADDR_W-1:0] PA = ADDR_W'(PHASE_BASE + g);

        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == FA) freq_q[g]  <= wr_data;
            if (wr_en && wr_addr == PA) phase_q[g] <= wr_data[PH_W-1:0];
        end

        assign freq_o[g]  = freq_q[g];
        assign phase_o[g] = phase_q[g];

        AST_FREQ_WRITE: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == FA) |=> freq_o[g] == $past(wr_data)) else $error("freq write lost"); // R1
        AST_PHASE_WRITE: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == PA) |=> phase_o[g] == $past(wr_data[PH_W-1:0])) else $error("phase write lost"); // R1
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
    assign ctrl_o = ctrl_q;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_o)) else $error("ctrl changed without write"); // R9
endmodule

// File: rtl/dds_select.sv
module dds_select
    import dds_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fsel_pin,
    input  logic  psel_pin,
    input  ctrl_t ctrl,
    output logic  fsel_q,
    output logic  psel_q
);
    logic fsel_d, psel_d;

    always_comb begin
        fsel_d = ctrl.sw_sel ? ctrl.fsel : fsel_pin;
        psel_d = ctrl.sw_sel ? ctrl.psel : psel_pin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q <= 1'b0;
            psel_q <= 1'b0;
        end else begin
            fsel_q <= fsel_d;
            psel_q <= psel_d;
        end
    end

    AST_SW_IGNORES_PIN: assert property (@(posedge clk) disable iff (rst)
        ctrl.sw_sel |=> (fsel_q == $past(ctrl.fsel)) && (psel_q == $past(ctrl.psel))) else $error("pin leaked into select"); // R6
    AST_PIN_DRIVES_SEL: assert property (@(posedge clk) disable iff (rst)
        !ctrl.sw_sel |=> (fsel_q == $past(fsel_pin)) && (psel_q == $past(psel_pin))) else $error("pin not followed"); // R4
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tune_t  freq  [NPAIR],
    input  phase_t phase [NPAIR],
    input  logic   fsel,
    input  logic   psel,
    output stage_t stage_o
);
    localparam int TOP_LSB = ACC_W - PH_W;

    tune_t  acc_q;
    tune_t  step;
    stage_t stage_q;

    assign step = freq[fsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            stage_q <= '0;
        end else begin
            acc_q         <= acc_q + step;
            stage_q.msb   <= acc_q[ACC_W-1];
            stage_q.phase <= acc_q[ACC_W-1:TOP_LSB] + phase[psel];
        end
    end

    assign stage_o = stage_q;

    AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage_o.msb == $past(acc_q[ACC_W-1])) else $error("sign stage misaligned"); // R11
    AST_ZERO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (step == '0) |=> $stable(acc_q)) else $error("accumulator moved on zero step"); // R3
endmodule

// File: rtl/dds_sine_map.sv
module dds_sine_map
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage_t           stage_i,
    output logic [DAC_W-1:0] dac_o,
    output logic             msb_o
);
    logic [AMP_W-1:0]  qtab [LUT_N];
    logic [LUT_AW-1:0] idx;
    logic [AMP_W-1:0]  mag;
    logic [DAC_W-1:0]  code;

    for (genvar i = 0; i < LUT_N; i++) begin : g_tab
        assign qtab[i] = quarter_amp(i);
    end

    always_comb begin
        idx  = stage_i.phase[PH_W-3 -: LUT_AW];
        if (stage_i.phase[PH_W-2]) idx = ~idx;
        mag  = qtab[idx];
        code = stage_i.phase[PH_W-1] ? (MIDSCALE - DAC_W'(mag)) : (MIDSCALE + DAC_W'(mag));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_o <= MIDSCALE;
            msb_o <= 1'b0;
        end else begin
            dac_o <= code;
            msb_o <= stage_i.msb;
        end
    end

    AST_MIDSCALE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_o == MIDSCALE) && !msb_o) else $error("no midscale after reset"); // R8
    AST_QUARTER_PEAK: assert property (@(posedge clk) disable iff (rst)
        (stage_i.phase == phase_t'(1 << (PH_W - 2))) |=> dac_o == {DAC_W{1'b1}}) else $error("peak code wrong"); // R7
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic              fsel_pin,
    input  logic              psel_pin,
    input  logic              sleep_pin,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_en,
    output logic              sign_out
);
    tune_t  freq  [NPAIR];
    phase_t phase [NPAIR];
    ctrl_t  ctrl;
    logic   fsel_q, psel_q;
    stage_t stage;
    logic   msb_q;

    dds_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freq_o(freq), .phase_o(phase), .ctrl_o(ctrl)
    );

    dds_select u_sel (
        .clk(clk), .rst(rst), .fsel_pin(fsel_pin), .psel_pin(psel_pin), .ctrl(ctrl),
        .fsel_q(fsel_q), .psel_q(psel_q)
    );

    dds_phase_acc u_acc (
        .clk(clk), .rst(rst), .freq(freq), .phase(phase), .fsel(fsel_q), .psel(psel_q),
        .stage_o(stage)
    );

    dds_sine_map u_map (
        .clk(clk), .rst(rst), .stage_i(stage), .dac_o(dac_code), .msb_o(msb_q)
    );

    assign dac_en   = ~(sleep_pin | ctrl.sleep);
    assign sign_out = ctrl.out_en & ctrl.sign_en & msb_q;

    AST_SLEEP_PIN: assert property (@(posedge clk) disable iff (rst)
        sleep_pin |-> !dac_en) else $error("dac enabled in sleep"); // R10
    AST_SIGN_GATED: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.out_en && ctrl.sign_en) |-> !sign_out) else $error("sign pin not gated"); // R11
endmodule

// File: tb/tb_dds_phase_core.sv
module tb_dds_phase_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;
    logic        fsel_pin = 1'b0, psel_pin = 1'b0, sleep_pin = 1'b0;
    logic [9:0]  dac_code;
    logic        dac_en, sign_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dds_phase_core dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fsel_pin(fsel_pin), .psel_pin(psel_pin), .sleep_pin(sleep_pin),
        .dac_code(dac_code), .dac_en(dac_en), .sign_out(sign_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 28'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // expected next (code, sign) for a quarter-turn step with zero offset
    function automatic int next_code(input int c, input bit s);
        if (c == 512 && !s) return 1023;
        if (c == 1023)      return 512;
        if (c == 512 && s)  return 1;
        return 512;
    endfunction
    function automatic bit next_sign(input int c, input bit s);
        if (c == 1023) return 1'b1;
        if (c == 1)    return 1'b0;
        return s;
    endfunction

    task automatic t_reset_state();
        check(dac_code == 10'd512, "R8 reset code", dac_code, 512);
        check(sign_out == 1'b0, "R8 reset sign", sign_out, 0);
        check(dac_en == 1'b1, "R10 awake after reset", dac_en, 1);
    endtask

    task automatic t_sine_points();
        int ph [5] = '{'h000, 'h200, 'h400, 'h800, 'hC00};
        int ex [5] = '{512, 873, 1023, 512, 1};
        for (int i = 0; i < 5; i++) begin
            wr(2, ph[i]);
            settle();
            check(dac_code == 10'(ex[i]), "R7 sine point via R1 write", dac_code, ex[i]);
        end
    endtask

    task automatic t_phase_select();
        wr(2, 'h400); wr(3, 'hC00);
        psel_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        check(dac_code == 10'd1023, "R12 not before third edge", dac_code, 1023);
        @(negedge clk);
        check(dac_code == 10'd1, "R12 psel pin at third edge", dac_code, 1);
        check(dac_code == 10'd1, "R5 phase offset 1", dac_code, 1);
        psel_pin = 1'b0; settle();
        check(dac_code == 10'd1023, "R5 phase offset 0", dac_code, 1023);
    endtask

    task automatic t_pin_ignored();
        wr(4, 'h05);
        settle();
        check(dac_code == 10'd1, "R6 psel bit", dac_code, 1);
        psel_pin = 1'b1; fsel_pin = 1'b1; settle();
        check(dac_code == 10'd1, "R6 pins ignored phase", dac_code, 1);
        repeat (3) @(negedge clk);
        check(dac_code == 10'd1, "R6 pins ignored freq", dac_code, 1);
        psel_pin = 1'b0; fsel_pin = 1'b0;
        wr(4, 'h00); settle();
        check(dac_code == 10'd1023, "R6 pin source restored", dac_code, 1023);
    endtask

    task automatic t_run_cycle(input string req);
        int c; bit s; int bad;
        c = dac_code; s = sign_out; bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (dac_code != 10'(next_code(c, s)) || sign_out != next_sign(c, s)) bad++;
            c = dac_code; s = sign_out;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_freq_select();
        wr(2, 0);
        wr(4, 'h30);
        fsel_pin = 1'b1; settle();
        t_run_cycle("R4 fsel pin quarter step with R11 sign");
        fsel_pin = 1'b0; settle();
        begin
            int c0 = dac_code;
            repeat (4) @(negedge clk);
            check(dac_code == 10'(c0), "R3 zero tuning word holds", dac_code, c0);
        end
        wr(4, 'h33); settle();
        t_run_cycle("R2 fsel control bit steps R3");
        wr(4, 'h31); settle();
    endtask

    task automatic t_sign_gate();
        int hi = 0;
        wr(4, 'h10);
        fsel_pin = 1'b1; settle();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (sign_out) hi++;
        end
        check(hi == 0, "R11 sign gated with bit5 clear", hi, 0);
        fsel_pin = 1'b0; settle();
    endtask

    task automatic t_sleep();
        sleep_pin = 1'b1; #1;
        check(dac_en == 1'b0, "R10 sleep pin", dac_en, 0);
        sleep_pin = 1'b0;
        wr(4, 'h08); #1;
        check(dac_en == 1'b0, "R10 sleep bit", dac_en, 0);
        wr(4, 'h00); #1;
        check(dac_en == 1'b1, "R10 awake", dac_en, 1);
    endtask

    task automatic t_reset_keeps();
        wr(0, 0); wr(2, 'h400); wr(4, 'h30);
        fsel_pin = 1'b0; psel_pin = 1'b0; settle();
        check(dac_code == 10'd1023, "R9 setup", dac_code, 1023);
        rst = 1'b1;
        @(negedge clk);
        check(dac_code == 10'd512, "R8 midscale in reset", dac_code, 512);
        check(sign_out == 1'b0, "R8 sign cleared", sign_out, 0);
        @(negedge clk);
        rst = 1'b0; settle();
        check(dac_code == 10'd1023, "R9 offset kept across reset", dac_code, 1023);
    endtask

    initial begin
        wr(0, 0); wr(1, 1 << 26); wr(2, 0); wr(3, 0); wr(4, 0);
        t_reset_state();
        @(negedge clk); rst = 1'b0;
        settle();
        t_sine_points();
        t_phase_select();
        t_pin_ignored();
        t_freq_select();
        t_sign_gate();
        t_sleep();
        t_reset_keeps();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule